// File: doc/BRIEF.md
# Telephony Master Clock Prescaler

This block turns a voice-codec master clock of 1.536, 1.544 or 2.048 MHz into a 256 kHz clock enable for the filter and sequencing logic. Alongside the enable it gives a phase count that is aligned to the frame. It runs on the master clock itself. A static select level and a parameter for the part variant choose between a divide by 8 (2.048 MHz) and a divide by 6 (1.536 or 1.544 MHz). Each 8 kHz frame therefore contains exactly 32 enables, whatever the rate.

The 8 kHz frame sync restarts the divider and the phase count. It also samples the select level, so the ratio can only change on a frame boundary. After the 32nd enable of a frame the block stops and waits for the next sync. A 1.536 MHz frame has 192 master cycles, so its sync arrives on the cycle that follows the last enable. A 1.544 MHz frame has 193 cycles, and its surplus cycle falls in the wait, where it produces no enable. No detection of the two rates is needed.

The control is a three-state machine:
- **ST_IDLE** is entered at reset. The block stays there until the first sync, with no enables and phase 0 (transition IDLE→RUN on sync).
- **ST_RUN** issues the enables. A sync restarts it (RUN→RUN). It leaves for the wait state on the 32nd enable (RUN→HOLD).
- **ST_HOLD** issues no enables and holds phase 31. It returns to ST_RUN on the next sync (HOLD→RUN).

Top module: `mclk_prescaler`

## Requirements
- R1: After reset, and until the first frame sync, tick_en is 0 and slot_phase is 0, whatever clk_sel does.
- R2: With ALAW_MAP=1, clk_sel sampled low gives a divide by 8 (a tick every 8 cycles) and sampled high gives a divide by 6.
- R3: A frame sync sampled at clock edge E makes the cycle after E frame cycle 0. In that cycle slot_phase is 0 and tick_en is 0. The first tick of the frame is in frame cycle R-1, where R is the divide ratio.
- R4: Within a frame, tick_en is high in cycles k*R-1 for k = 1..32, and only in those cycles. Frame cycle c shows slot_phase = c/R (integer division).
- R5: Once the 32nd tick has been issued, no further tick occurs until the next frame sync, and slot_phase stays 31. A 193-cycle frame at divide-by-6 therefore has one idle cycle before its sync.
- R6: A frame sync that arrives before the 32nd tick restarts the divider and phase at once, as in R3.
- R7: clk_sel is sampled only when a frame sync is taken. A change of clk_sel in the middle of a frame does not alter the tick spacing before the next sync.
- R8: With ALAW_MAP=0 the mapping is inverted: clk_sel high gives a divide by 8 and clk_sel low gives a divide by 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 1 | Rate select level, sampled at frame sync |
| frame_sync | input | 1 | One-cycle 8 kHz frame start pulse, synchronous to clk |
| tick_en | output | 1 | 256 kHz clock enable, one cycle wide |
| slot_phase | output | 5 | Index of the current enable slot in the frame (0..31) |

## Verification
The assertions assume that frame_sync is a single-cycle pulse synchronous to the master clock. They also assume that clk_sel matters only in the cycle of the sync. They place no demand on the spacing between syncs, so early and late syncs stay inside what the checks allow. The stimulus drives both inputs on the falling clock edge and raises each sync for exactly one cycle. It uses frame lengths of 37, 100, 192, 193, 256 and 300 cycles. Both variant mappings are driven with the same stimulus, and clk_sel is toggled in the middle of frames.

// File: rtl/mclk_prescaler_pkg.sv
package mclk_prescaler_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } pre_state_e;

endpackage

// File: rtl/mclk_rate_latch.sv
module mclk_rate_latch #(
    parameter bit ALAW_MAP = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_lvl,
    input  logic sync,
    output logic fast_q
);

    logic fast_d;

    generate
        if (ALAW_MAP) begin : g_alaw
            assign fast_d = ~sel_lvl;
        end else begin : g_mulaw
            assign fast_d = sel_lvl;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
        end else if (sync) begin
            fast_q <= fast_d;
        end
    end

    // R7: ratio only moves on a frame sync
    p_rate_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sync |=> $stable(fast_q));

endmodule

// File: rtl/mclk_div_counter.sv
module mclk_div_counter #(
    parameter int SLOW_DIV = 6,
    parameter int FAST_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    input  logic fast,
    output logic wrap
);

    localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
    localparam int DIV_W   = $clog2(MAX_DIV);
    localparam logic [DIV_W-1:0] FAST_LIM = DIV_W'(FAST_DIV - 1);
    localparam logic [DIV_W-1:0] SLOW_LIM = DIV_W'(SLOW_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;

    assign lim  = fast ? FAST_LIM : SLOW_LIM;
    assign wrap = (div_q == lim);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (restart) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= wrap ? '0 : div_q + 1'b1;
        end
    end

    // R3: sync restarts the divider phase
    p_div_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (div_q == '0));

    // R2: divider never runs past the selected limit
    p_div_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_q <= lim);

endmodule

// File: rtl/mclk_prescaler.sv
module mclk_prescaler
    import mclk_prescaler_pkg::*;
#(
    parameter bit ALAW_MAP = 1'b1,
    parameter int SLOW_DIV = 6,
    parameter int FAST_DIV = 8,
    parameter int SLOTS    = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clk_sel,
    input  logic                     frame_sync,
    output logic                     tick_en,
    output logic [$clog2(SLOTS)-1:0] slot_phase
);

    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    pre_state_e        state_q, state_nx;
    logic              fast_q;
    logic              wrap;
    logic              last_tick;
    logic [SLOT_W-1:0] slot_q;

    mclk_rate_latch #(.ALAW_MAP(ALAW_MAP)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_lvl (clk_sel),
        .sync    (frame_sync),
        .fast_q  (fast_q)
    );

    mclk_div_counter #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (frame_sync),
        .run     (state_q == ST_RUN),
        .fast    (fast_q),
        .wrap    (wrap)
    );

    assign last_tick = (state_q == ST_RUN) && wrap && (slot_q == LAST_SLOT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (frame_sync) state_nx = ST_RUN;
            ST_RUN: begin
                if (frame_sync)     state_nx = ST_RUN;
                else if (last_tick) state_nx = ST_HOLD;
            end
            ST_HOLD: if (frame_sync) state_nx = ST_RUN;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (frame_sync) begin
            slot_q <= '0;
        end else if ((state_q == ST_RUN) && wrap && (slot_q != LAST_SLOT)) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    always_comb begin
        tick_en    = (state_q == ST_RUN) && wrap;
        slot_phase = slot_q;
    end

    // R3/R6: a sync gives phase 0 and no tick in frame cycle 0
    p_sync_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> (slot_phase == '0) && !tick_en);

    // R4: each tick below the last advances the phase by one
    p_phase_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !frame_sync && (slot_phase != LAST_SLOT))
        |=> (slot_phase == $past(slot_phase) + 1'b1));

    // R5: after the last slot the block goes quiet and holds the phase
    p_frame_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !frame_sync && (slot_phase == LAST_SLOT))
        |=> !tick_en && (slot_phase == LAST_SLOT));

    // R1: nothing leaves the idle state except a sync
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && !frame_sync |=> (state_q == ST_IDLE) && !tick_en);

endmodule

// File: tb/mclk_prescaler_tb.sv
module mclk_prescaler_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_sel = 1'b0;
    logic       frame_sync = 1'b0;
    logic       tick_a, tick_m;
    logic [4:0] ph_a, ph_m;

    int    checks = 0;
    int    errors = 0;
    bit    prev_ok = 1'b0;
    int    prev_len = 0;
    bit    prev_sel = 1'b0;
    string prev_tag = "";

    always #4 clk = ~clk;

    mclk_prescaler #(.ALAW_MAP(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .frame_sync(frame_sync),
        .tick_en(tick_a), .slot_phase(ph_a)
    );

    mclk_prescaler #(.ALAW_MAP(1'b0)) u_dut_mu (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .frame_sync(frame_sync),
        .tick_en(tick_m), .slot_phase(ph_m)
    );

    task automatic cmp(string tag, logic gt, logic et, int gp, int ep);
        checks++;
        if (gt !== et || gp != ep) begin
            errors++;
            $display("FAIL %s tick=%0b phase=%0d expected tick=%0b phase=%0d",
                     tag, gt, gp, et, ep);
        end
    endtask

    // expected outputs in frame cycle c for divide ratio r
    task automatic check_cycle(int c, bit sel, string tag);
        int  r_a, r_m;
        bit  et;
        int  ep;
        r_a = sel ? 6 : 8;   // A-law mapping, R2
        r_m = sel ? 8 : 6;   // inverted mapping, R8
        et = (c < 32 * r_a) && (c % r_a == r_a - 1);
        ep = (c < 32 * r_a) ? c / r_a : 31;
        cmp(tag, tick_a, et, int'(ph_a), ep);
        et = (c < 32 * r_m) && (c % r_m == r_m - 1);
        ep = (c < 32 * r_m) ? c / r_m : 31;
        cmp("R8", tick_m, et, int'(ph_m), ep);
    endtask

    // called at a falling edge: this cycle carries the sync
    task automatic frame(bit sel, int len, int flip_at, string tag);
        if (prev_ok) check_cycle(prev_len - 1, prev_sel, prev_tag);
        frame_sync = 1'b1;
        clk_sel    = sel;
        @(negedge clk);
        frame_sync = 1'b0;
        for (int c = 0; c < len - 1; c++) begin
            check_cycle(c, sel, tag);
            if (c == flip_at) clk_sel = ~sel;   // R7 mid-frame change
            @(negedge clk);
        end
        prev_ok  = 1'b1;
        prev_len = len;
        prev_sel = sel;
        prev_tag = tag;
    endtask

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL R1 watchdog expired tick=%0b phase=%0d expected run to end", tick_a, ph_a);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle until the first sync, select ignored
        for (int i = 0; i < 12; i++) begin
            cmp("R1", tick_a, 1'b0, int'(ph_a), 0);
            cmp("R1", tick_m, 1'b0, int'(ph_m), 0);
            clk_sel = ~clk_sel;
            @(negedge clk);
        end
        frame(1'b0, 256, -1, "R3");
        frame(1'b0, 256, -1, "R2");
        frame(1'b1, 192, -1, "R4");
        frame(1'b1, 192, -1, "R4");
        frame(1'b1, 193, -1, "R5");
        frame(1'b1, 193, -1, "R5");
        frame(1'b1, 193, -1, "R5");
        frame(1'b1, 100, -1, "R6");
        frame(1'b0, 37,  -1, "R6");
        frame(1'b0, 256, 40, "R7");
        frame(1'b1, 193, 20, "R7");
        frame(1'b0, 300, -1, "R5");
        frame(1'b1, 192, 100, "R2");
        check_cycle(prev_len - 1, prev_sel, prev_tag);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule